// File: doc/BRIEF.md
# Distributed-Arithmetic FIR Filter

This block is a four-tap finite impulse response filter for unsigned 8-bit samples that contains no multiplier. Its coefficients are fixed at elaboration time. From them the block computes a small lookup table holding every possible sum of the coefficients. The filter then works through the tap delay line one bit position per clock. On each step it gathers the same bit of every tap into a table address and adds the selected word into a right-shifting accumulator.

A sample is presented with a one-cycle valid strobe. When the filter is idle it takes the sample, moves the delay line along by one, and spends the next eight clocks on the bit-serial sum. The full-precision result then appears on the output together with a one-cycle valid pulse. A sample offered while a sum is in progress is dropped. The cycle in which the result is shown is already idle, so a new sample can be accepted in that same cycle.

Top module: `dafir_filter`

## Requirements
- R1: A synchronous reset clears the delay line, the accumulator and the output, and holds `res_valid` low. After reset, the first result depends only on the first sample taken.
- R2: Each result equals c0*x[n] + c1*x[n-1] + c2*x[n-2] + c3*x[n-3]. The samples are unsigned and the result is kept to the full 18 bits with no truncation. The default coefficients are c0=37, c1=100, c2=200 and c3=250.
- R3: Table entry k holds the sum of every coefficient ci whose bit i in k is set. Address bit i comes from tap i, and tap 0 holds the newest sample. An impulse therefore yields c0, c1, c2, c3 on successive results.
- R4: A sample is taken at the clock edge that ends the cycle in which `smp_valid` is high and the filter is idle. `res_valid` is high in the ninth cycle after that cycle and low in the eighth cycle after it.
- R5: `res_valid` is high for exactly one cycle per accepted sample.
- R6: While a computation is running, `smp_valid` has no effect. The delay line does not shift, and neither the current result nor any later one reflects the dropped sample.
- R7: A sample presented in the cycle in which `res_valid` is high is accepted. It does not disturb the result on display, and its own result follows with the R4 timing.
- R8: Full-scale inputs (255 in every tap) give 149685 with no overflow.
- R9: A reset asserted while a computation is running cancels it. No `res_valid` follows until a new sample is taken, and that sample sees an empty delay line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 8 | Unsigned sample |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 18 | Full-precision unsigned filter output |

## Verification
Two events can fall in the same cycle: the output strobe of one computation and the acceptance of the next sample. The bench provokes this by presenting every new sample in the very cycle in which the previous result is shown. It then checks that the displayed result still matches the earlier window, and that the next result includes the new sample with the normal nine-cycle latency. A second pairing is a sample offered during a running computation. The bench shows that it is dropped by comparing later results against a history that leaves it out.

// File: rtl/dafir_pkg.sv
package dafir_pkg;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } dafir_phase_e;

   function automatic int unsigned sel_bits(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((1 << w) < n) w++;
      return w;
   endfunction

endpackage

// File: rtl/dafir_coef_rom.sv
module dafir_coef_rom #(
   parameter int unsigned           NTAPS = 4,
   parameter int unsigned           CW    = 8,
   parameter int unsigned           ROM_W = 10,
   parameter logic [NTAPS*CW-1:0]   COEFS = '0
) (
   input  logic [NTAPS-1:0] addr,
   output logic [ROM_W-1:0] word
);
   localparam int unsigned DEPTH = 1 << NTAPS;

   function automatic int unsigned entry_sum(input int unsigned k);
      int unsigned s;
      s = 0;
      for (int i = 0; i < NTAPS; i++)
         if (((k >> i) & 1) != 0) s += int'(COEFS[i*CW +: CW]);
      return s;
   endfunction

   localparam int unsigned FULL_SUM = entry_sum(DEPTH - 1);

   generate
      if (FULL_SUM > (1 << ROM_W) - 1) begin : g_width_err
         $error("dafir_coef_rom: coefficient sum does not fit ROM_W bits");
      end
   endgenerate

   logic [ROM_W-1:0] table_w [DEPTH];

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_entry
         assign table_w[e] = ROM_W'(entry_sum(e));
      end
   endgenerate

   assign word = table_w[addr];

endmodule

// File: rtl/dafir_bit_slice.sv
module dafir_bit_slice #(
   parameter int unsigned NTAPS = 4,
   parameter int unsigned DW    = 8,
   parameter int unsigned SELW  = 3
) (
   input  logic [NTAPS*DW-1:0] taps_flat,
   input  logic [SELW-1:0]     sel,
   output logic [NTAPS-1:0]    addr
);
   generate
      for (genvar i = 0; i < NTAPS; i++) begin : g_tap
         logic [DW-1:0] word_w;
         assign word_w  = taps_flat[i*DW +: DW];
         assign addr[i] = word_w[sel];
      end
   endgenerate
endmodule

// File: rtl/dafir_accum.sv
module dafir_accum #(
   parameter int unsigned DW    = 8,
   parameter int unsigned ROM_W = 10
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  clr,
   input  logic                  step,
   input  logic [ROM_W-1:0]      word,
   output logic [ROM_W+DW-1:0]   full_nxt
);
   logic [ROM_W:0]   acc_q;
   logic [DW-1:0]    low_q;
   logic [ROM_W:0]   sum_w;
   logic [ROM_W:0]   acc_nxt;
   logic [DW-1:0]    low_nxt;

   always_comb begin
      sum_w    = acc_q + {1'b0, word};
      acc_nxt  = {1'b0, sum_w[ROM_W:1]};
      low_nxt  = {sum_w[0], low_q[DW-1:1]};
      full_nxt = {sum_w[ROM_W:1], low_nxt};
   end

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         acc_q <= '0;
         low_q <= '0;
      end else if (step) begin
         acc_q <= acc_nxt;
         low_q <= low_nxt;
      end
   end
endmodule

// File: rtl/dafir_filter.sv
module dafir_filter
   import dafir_pkg::*;
#(
   parameter int unsigned         NTAPS = 4,
   parameter int unsigned         DW    = 8,
   parameter int unsigned         CW    = 8,
   parameter int unsigned         ROM_W = 10,
   parameter logic [NTAPS*CW-1:0] COEFS = {8'd250, 8'd200, 8'd100, 8'd37}
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 smp_valid,
   input  logic [DW-1:0]        smp_data,
   output logic                 res_valid,
   output logic [ROM_W+DW-1:0]  res_data
);
   localparam int unsigned SELW  = sel_bits(DW);
   localparam int unsigned OUT_W = ROM_W + DW;

   generate
      if (NTAPS < 1 || NTAPS > 8) begin : g_ntaps_err
         $error("dafir_filter: NTAPS must be 1..8");
      end
      if (DW < 2) begin : g_dw_err
         $error("dafir_filter: DW must be at least 2");
      end
   endgenerate

   dafir_phase_e          phase_q;
   logic [SELW-1:0]       cnt_q;
   logic                  busy;
   logic                  accept;
   logic                  last;
   logic [DW-1:0]         tap_q [NTAPS];
   logic [NTAPS*DW-1:0]   taps_flat;
   logic [NTAPS-1:0]      rom_addr;
   logic [ROM_W-1:0]      rom_word;
   logic [OUT_W-1:0]      full_nxt;
   logic                  res_valid_q;
   logic [OUT_W-1:0]      res_data_q;

   assign busy   = (phase_q == PH_RUN);
   assign accept = smp_valid && !busy;
   assign last   = busy && (cnt_q == SELW'(DW - 1));

   generate
      for (genvar i = 0; i < NTAPS; i++) begin : g_tap
         if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (rst)         tap_q[i] <= '0;
               else if (accept) tap_q[i] <= smp_data;
            end
         end else begin : g_body
            always_ff @(posedge clk) begin
               if (rst)         tap_q[i] <= '0;
               else if (accept) tap_q[i] <= tap_q[i-1];
            end
         end
         assign taps_flat[i*DW +: DW] = tap_q[i];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else if (accept) begin
         phase_q <= PH_RUN;
         cnt_q   <= '0;
      end else if (last) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else if (busy) begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   dafir_bit_slice #(.NTAPS(NTAPS), .DW(DW), .SELW(SELW)) u_slice (
      .taps_flat (taps_flat),
      .sel       (cnt_q),
      .addr      (rom_addr)
   );

   dafir_coef_rom #(.NTAPS(NTAPS), .CW(CW), .ROM_W(ROM_W), .COEFS(COEFS)) u_rom (
      .addr (rom_addr),
      .word (rom_word)
   );

   dafir_accum #(.DW(DW), .ROM_W(ROM_W)) u_acc (
      .clk      (clk),
      .rst      (rst),
      .clr      (accept),
      .step     (busy),
      .word     (rom_word),
      .full_nxt (full_nxt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         res_valid_q <= 1'b0;
         res_data_q  <= '0;
      end else begin
         res_valid_q <= last;
         if (last) res_data_q <= full_nxt;
      end
   end

   assign res_valid = res_valid_q;
   assign res_data  = res_data_q;

endmodule

// File: rtl/dafir_filter_chk.sv
module dafir_filter_chk #(
   parameter int unsigned DW = 8
) (
   input logic          clk,
   input logic          rst,
   input logic          smp_valid,
   input logic          accept,
   input logic          busy,
   input logic          res_valid,
   input logic [DW-1:0] tap0
);
   localparam int unsigned CW_CNT = $clog2(DW + 2) + 1;
   localparam logic [CW_CNT-1:0] DONE_AT = CW_CNT'(DW + 1);

   logic [CW_CNT-1:0] since_q;

   always_ff @(posedge clk) begin
      if (rst)                                   since_q <= '0;
      else if (accept)                           since_q <= CW_CNT'(1);
      else if (since_q != 0 && since_q != DONE_AT) since_q <= since_q + 1'b1;
      else                                       since_q <= '0;
   end

   a_r4_latency: assert property (@(posedge clk) disable iff (rst)
      res_valid |-> (since_q == DONE_AT));

   a_r4_timely: assert property (@(posedge clk) disable iff (rst)
      (since_q == DONE_AT) |-> res_valid);

   a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
      res_valid |=> !res_valid);

   a_r6_taps_hold: assert property (@(posedge clk) disable iff (rst)
      (smp_valid && busy) |=> $stable(tap0));

   a_r7_idle_at_result: assert property (@(posedge clk) disable iff (rst)
      res_valid |-> !busy);

   a_r9_reset_quiet: assert property (@(posedge clk)
      rst |=> !res_valid);

endmodule

bind dafir_filter dafir_filter_chk #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .smp_valid (smp_valid),
   .accept    (accept),
   .busy      (busy),
   .res_valid (res_valid),
   .tap0      (tap_q[0])
);

// File: tb/tb_dafir_filter.sv
module tb_dafir_filter;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        smp_valid = 1'b0;
   logic [7:0]  smp_data = '0;
   logic        res_valid;
   logic [17:0] res_data;

   int errors = 0;
   int checks = 0;
   int cyc    = 0;
   int hist [4];
   int coef [4] = '{37, 100, 200, 250};

   always #10 clk = ~clk;

   dafir_filter dut (
      .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
      .res_valid(res_valid), .res_data(res_data)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         errors++; checks++;
         $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
      end
   endtask

   function automatic int model();
      int s = 0;
      for (int i = 0; i < 4; i++) s += coef[i] * hist[i];
      return s;
   endfunction

   task automatic clear_hist();
      for (int i = 0; i < 4; i++) hist[i] = 0;
   endtask

   // Called just after a negedge with the filter idle; returns at the
   // negedge where the result is shown. junk=1 offers a sample mid-run (R6).
   task automatic do_sample(input int x, input string req, input bit junk);
      int exp;
      for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = x;
      exp = model();
      smp_valid = 1'b1;
      smp_data  = 8'(x);
      for (int k = 1; k <= 9; k++) begin
         @(negedge clk);
         if (k == 1) smp_valid = 1'b0;
         if (junk && k == 3) begin smp_valid = 1'b1; smp_data = 8'hA5; end
         if (junk && k == 5) smp_valid = 1'b0;
         if (k == 8) check({req, " R4 early"}, int'(res_valid), 0);
      end
      check({req, " R4 strobe"}, int'(res_valid), 1);
      check({req, " value"}, int'(res_data), exp);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      clear_hist();
      check("R1 reset valid", int'(res_valid), 0);
      check("R1 reset data", int'(res_data), 0);
   endtask

   task automatic t_impulse();
      do_sample(1, "R3 impulse c0", 0);
      do_sample(0, "R3 impulse c1", 0);
      do_sample(0, "R3 impulse c2", 0);
      do_sample(0, "R3 impulse c3", 0);
      @(negedge clk);
      check("R5 pulse width", int'(res_valid), 0);
   endtask

   task automatic t_concurrent();
      // each call begins in the cycle the previous result is shown (R7)
      do_sample(12, "R7 first", 0);
      smp_valid = 1'b1;
      smp_data  = 8'd99;
      check("R7 held result", int'(res_data), model());
      do_sample(99, "R7 second R2", 0);
      do_sample(200, "R2 mix", 0);
      do_sample(3, "R2 mix2", 0);
      @(negedge clk);
      check("R5 after R7", int'(res_valid), 0);
   endtask

   task automatic t_full_scale();
      for (int i = 0; i < 4; i++) do_sample(255, "R8 full", 0);
      check("R8 full-scale", int'(res_data), 149685);
      @(negedge clk);
   endtask

   task automatic t_busy_ignore();
      do_sample(7, "R6 drop", 1);
      do_sample(0, "R6 next", 0);
      @(negedge clk);
   endtask

   task automatic t_lfsr();
      logic [7:0] lf = 8'h5B;
      for (int n = 0; n < 10; n++) begin
         lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
         do_sample(int'(lf), "R2 pattern", 0);
      end
      @(negedge clk);
   endtask

   task automatic t_mid_reset();
      int seen = 0;
      smp_valid = 1'b1;
      smp_data  = 8'd77;
      @(negedge clk);
      smp_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      clear_hist();
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         if (res_valid) seen++;
      end
      check("R9 no strobe after abort", seen, 0);
      do_sample(5, "R9 R1 empty line", 0);
      @(negedge clk);
   endtask

   initial begin
      clear_hist();
      @(negedge clk);
      t_reset();
      t_impulse();
      t_concurrent();
      t_full_scale();
      t_busy_ignore();
      t_lfsr();
      t_mid_reset();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule